// File: doc/BRIEF.md
# Exception Entry and Vector Controller

This block sits beside a processor core's program-status logic and decides when the core leaves normal execution for an exception handler. Each cycle it looks at seven request lines: reset, undefined instruction, software interrupt, prefetch abort, data abort, normal interrupt and fast interrupt. It masks the two interrupt lines with the disable bits of the status word, picks the request with the highest priority, and produces the handler address, the new processor mode and the rewritten status word. It also produces the link-register value and a write of the saved-status copy that belongs to the target mode.

The block owns the current status word (CPSR) and the five mode-banked saved copies (SPSRs). The core changes the status word directly through a load port. It leaves a handler through a return request, which copies the current mode's saved status back into the CPSR. Instruction fetch and the interrupt source controller live elsewhere.

The control is a three-state machine. `S_RUN` is the idle state in which requests, returns and loads are accepted. `S_ENTER` lasts one cycle, is entered on the transition *take*, and raises the entry pulse. `S_RETURN` lasts one cycle and is entered on the transition *restore*. Both one-cycle states go back to `S_RUN` unconditionally on the transition *resume*. In `S_RUN`, a load or an ignored return keeps the block in `S_RUN`.

Top module: `exc_vector_ctrl`

## Requirements
- R1: After `rst_n` is released, `cpsr_o` is 0x000000D3 (supervisor mode 0x13, bits 7 and 6 set), and `take_o` and `spsr_we_o` are 0.
- R2: Each exception has a fixed vector and target mode, with mode codes user 0x10, fast interrupt 0x11, interrupt 0x12, supervisor 0x13, abort 0x17, undefined 0x1B and system 0x1F. The vectors are: reset 0x00 (0x13), undefined 0x04 (0x1B), software interrupt 0x08 (0x13), prefetch abort 0x0C (0x17), data abort 0x10 (0x17), interrupt 0x18 (0x12), fast interrupt 0x1C (0x11).
- R3: When several requests are pending, the winner is chosen in this order: reset, data abort, fast interrupt, interrupt, prefetch abort, undefined instruction, software interrupt.
- R4: An interrupt request is ignored while CPSR bit 7 is 1, and a fast-interrupt request is ignored while CPSR bit 6 is 1. A masked request causes no entry and leaves the CPSR unchanged.
- R5: On entry, the new CPSR keeps bits 31..8 of the old one, sets bit 7, clears bit 5 and puts the target mode in bits 4..0. Bit 6 is set for reset and fast interrupt and is kept for all other exceptions.
- R6: On entry, `spsr_we_o` is 1 and `spsr_wdata_o` holds the CPSR from before the entry. `spsr_sel_o` names the target bank: fast interrupt 0, interrupt 1, supervisor 2, abort 3, undefined 4.
- R7: On entry, `lr_o` is the `pc_i` sampled with the request plus 4.
- R8: Entry outputs appear in the cycle after the request is sampled. `take_o` is high for exactly one cycle, and requests sampled while `take_o` is high are ignored.
- R9: A return request sampled in an exception mode loads the CPSR from that mode's saved copy, visible in the next cycle.
- R10: A return request in user or system mode is ignored and leaves the CPSR unchanged.
- R11: In the idle state, with no entry and no effective return, `cpsr_wr` loads `cpsr_wdata` into the CPSR in the next cycle.
- R12: The reserved vector 0x14 is never produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_reset | input | 1 | Reset exception request |
| req_undef | input | 1 | Undefined-instruction request |
| req_swi | input | 1 | Software-interrupt request |
| req_pabt | input | 1 | Prefetch-abort request |
| req_dabt | input | 1 | Data-abort request |
| req_irq | input | 1 | Interrupt request |
| req_fiq | input | 1 | Fast-interrupt request |
| pc_i | input | 32 | Current program counter |
| cpsr_wr | input | 1 | Load the status word |
| cpsr_wdata | input | 32 | Value for a status-word load |
| ret_req | input | 1 | Return from exception: restore the saved status |
| take_o | output | 1 | One-cycle pulse marking an exception entry |
| vector_o | output | 32 | Handler address |
| mode_o | output | 5 | Target mode |
| cpsr_o | output | 32 | Current status word |
| spsr_we_o | output | 1 | Saved-status write strobe |
| spsr_sel_o | output | 3 | Saved-status bank index |
| spsr_wdata_o | output | 32 | Status value being saved |
| lr_o | output | 32 | Link-register value for the target mode |

## Verification
On every cycle the assertions check the following. The entry pulse lasts one cycle. An entry always comes with a saved-status write of the previous status word. The new status word agrees with the reported mode, with bit 7 set and bit 5 clear. The reserved vector never appears. The link value follows the sampled PC. An interrupt entry never starts while bit 7 was set. A return in user or system mode leaves the status word untouched. Only the bench scenarios can show the full priority ranking across every pair of requests, the exact vector and mode for each exception, and masked interrupts losing to lower-priority requests. The same holds for the round trip of an entry followed by a return that restores the saved value.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int XLEN      = 32;
    localparam int MODE_W    = 5;
    localparam int NUM_BANKS = 5;
    localparam int BANK_W    = $clog2(NUM_BANKS);

    localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
    localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'h1F;

    // The encoding is the vector slot index; slot 5 is reserved.
    typedef enum logic [2:0] {
        EX_RESET = 3'd0,
        EX_UNDEF = 3'd1,
        EX_SWI   = 3'd2,
        EX_PABT  = 3'd3,
        EX_DABT  = 3'd4,
        EX_IRQ   = 3'd6,
        EX_FIQ   = 3'd7
    } exc_e;

    typedef enum logic [1:0] {
        S_RUN    = 2'd0,
        S_ENTER  = 2'd1,
        S_RETURN = 2'd2
    } state_e;

    function automatic logic [MODE_W-1:0] target_mode(exc_e e);
        case (e)
            EX_UNDEF:         return MODE_UND;
            EX_PABT, EX_DABT: return MODE_ABT;
            EX_IRQ:           return MODE_IRQ;
            EX_FIQ:           return MODE_FIQ;
            default:          return MODE_SVC;
        endcase
    endfunction

    function automatic logic [BANK_W-1:0] bank_of(logic [MODE_W-1:0] m);
        case (m)
            MODE_FIQ: return BANK_W'(0);
            MODE_IRQ: return BANK_W'(1);
            MODE_SVC: return BANK_W'(2);
            MODE_ABT: return BANK_W'(3);
            default:  return BANK_W'(4);
        endcase
    endfunction

    function automatic logic has_bank(logic [MODE_W-1:0] m);
        return (m == MODE_FIQ) || (m == MODE_IRQ) || (m == MODE_SVC) ||
               (m == MODE_ABT) || (m == MODE_UND);
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic req_reset,
    input  logic req_undef,
    input  logic req_swi,
    input  logic req_pabt,
    input  logic req_dabt,
    input  logic req_irq,
    input  logic req_fiq,
    input  logic irq_masked,
    input  logic fiq_masked,
    output logic valid,
    output exc_e sel
);
    // Fixed ranking, highest first.
    always_comb begin
        valid = 1'b1;
        sel   = EX_RESET;
        if (req_reset)                     sel = EX_RESET;
        else if (req_dabt)                 sel = EX_DABT;
        else if (req_fiq && !fiq_masked)   sel = EX_FIQ;
        else if (req_irq && !irq_masked)   sel = EX_IRQ;
        else if (req_pabt)                 sel = EX_PABT;
        else if (req_undef)                sel = EX_UNDEF;
        else if (req_swi)                  sel = EX_SWI;
        else                               valid = 1'b0;
    end
endmodule

// File: rtl/exc_spsr_bank.sv
module exc_spsr_bank
    import exc_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int BANKS = NUM_BANKS,
    localparam int IW   = $clog2(BANKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ridx,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] saved [BANKS];

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         saved[g] <= '0;
            else if (we && widx == IW'(g))      saved[g] <= wdata;
        end
    end

    assign rdata = (int'(ridx) < BANKS) ? saved[ridx] : '0;
endmodule

// File: rtl/exc_vector_ctrl.sv
module exc_vector_ctrl
    import exc_pkg::*;
#(
    parameter logic [31:0] VEC_BASE  = 32'h0000_0000,
    parameter logic [31:0] LR_OFFSET = 32'd4,
    parameter logic [31:0] CPSR_INIT = 32'h0000_00D3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_reset,
    input  logic        req_undef,
    input  logic        req_swi,
    input  logic        req_pabt,
    input  logic        req_dabt,
    input  logic        req_irq,
    input  logic        req_fiq,
    input  logic [31:0] pc_i,
    input  logic        cpsr_wr,
    input  logic [31:0] cpsr_wdata,
    input  logic        ret_req,
    output logic        take_o,
    output logic [31:0] vector_o,
    output logic [4:0]  mode_o,
    output logic [31:0] cpsr_o,
    output logic        spsr_we_o,
    output logic [2:0]  spsr_sel_o,
    output logic [31:0] spsr_wdata_o,
    output logic [31:0] lr_o
);
    localparam int I_BIT = 7;
    localparam int F_BIT = 6;
    localparam int T_BIT = 5;
    localparam logic [31:0] VEC_RSVD = VEC_BASE + 32'h14;

    state_e state, state_nx;
    logic   arb_valid;
    exc_e   arb_sel;
    logic   go_enter, ret_ok, wr_ok;
    logic [31:0] cpsr_q, cpsr_entry, spsr_rd;
    logic [MODE_W-1:0] tgt_mode;
    logic [BANK_W-1:0] tgt_bank;

    exc_arbiter u_arb (
        .req_reset  (req_reset),
        .req_undef  (req_undef),
        .req_swi    (req_swi),
        .req_pabt   (req_pabt),
        .req_dabt   (req_dabt),
        .req_irq    (req_irq),
        .req_fiq    (req_fiq),
        .irq_masked (cpsr_q[I_BIT]),
        .fiq_masked (cpsr_q[F_BIT]),
        .valid      (arb_valid),
        .sel        (arb_sel)
    );

    exc_spsr_bank #(.W(XLEN), .BANKS(NUM_BANKS)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (go_enter),
        .widx  (tgt_bank),
        .wdata (cpsr_q),
        .ridx  (bank_of(cpsr_q[4:0])),
        .rdata (spsr_rd)
    );

    assign tgt_mode = target_mode(arb_sel);
    assign tgt_bank = bank_of(tgt_mode);

    // Status word after entry: I set, T cleared, F set for reset and FIQ.
    always_comb begin
        cpsr_entry           = cpsr_q;
        cpsr_entry[I_BIT]    = 1'b1;
        cpsr_entry[T_BIT]    = 1'b0;
        cpsr_entry[4:0]      = tgt_mode;
        if (arb_sel == EX_RESET || arb_sel == EX_FIQ)
            cpsr_entry[F_BIT] = 1'b1;
    end

    assign go_enter = (state == S_RUN) && arb_valid;
    assign ret_ok   = (state == S_RUN) && !arb_valid && ret_req && has_bank(cpsr_q[4:0]);
    assign wr_ok    = (state == S_RUN) && !arb_valid && !ret_ok && cpsr_wr;

    // Next-state logic: take, restore, resume.
    always_comb begin
        state_nx = state;
        unique case (state)
            S_RUN: begin
                if (go_enter)    state_nx = S_ENTER;
                else if (ret_ok) state_nx = S_RETURN;
            end
            S_ENTER:  state_nx = S_RUN;
            S_RETURN: state_nx = S_RUN;
            default:  state_nx = S_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_RUN;
        else        state <= state_nx;
    end

    // Datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpsr_q       <= CPSR_INIT;
            vector_o     <= VEC_BASE;
            mode_o       <= MODE_SVC;
            lr_o         <= '0;
            spsr_sel_o   <= '0;
            spsr_wdata_o <= '0;
        end else if (go_enter) begin
            cpsr_q       <= cpsr_entry;
            vector_o     <= VEC_BASE + {27'd0, arb_sel, 2'b00};
            mode_o       <= tgt_mode;
            lr_o         <= pc_i + LR_OFFSET;
            spsr_sel_o   <= 3'(tgt_bank);
            spsr_wdata_o <= cpsr_q;
        end else if (ret_ok) begin
            cpsr_q       <= spsr_rd;
        end else if (wr_ok) begin
            cpsr_q       <= cpsr_wdata;
        end
    end

    assign take_o    = (state == S_ENTER);
    assign spsr_we_o = (state == S_ENTER);
    assign cpsr_o    = cpsr_q;

    p_take_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    p_no_rsvd_vec_r12: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> vector_o != VEC_RSVD);

    p_entry_cpsr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (cpsr_o[4:0] == mode_o && cpsr_o[I_BIT] && !cpsr_o[T_BIT]));

    p_spsr_save_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (spsr_we_o && spsr_wdata_o == $past(cpsr_o)));

    p_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> lr_o == $past(pc_i) + LR_OFFSET);

    p_irq_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && mode_o == MODE_IRQ) |-> !$past(cpsr_o[I_BIT]));

    p_ret_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && ret_req && !cpsr_wr && !arb_valid &&
         (cpsr_o[4:0] == MODE_USR || cpsr_o[4:0] == MODE_SYS)) |=> $stable(cpsr_o));
endmodule

// File: tb/exc_vector_ctrl_bench.sv
module exc_vector_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_reset = 0, req_undef = 0, req_swi = 0, req_pabt = 0;
    logic        req_dabt = 0, req_irq = 0, req_fiq = 0;
    logic [31:0] pc_i = '0;
    logic        cpsr_wr = 0;
    logic [31:0] cpsr_wdata = '0;
    logic        ret_req = 0;
    logic        take_o, spsr_we_o;
    logic [31:0] vector_o, cpsr_o, spsr_wdata_o, lr_o;
    logic [4:0]  mode_o;
    logic [2:0]  spsr_sel_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    exc_vector_ctrl u_exc_vector_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_reset(req_reset), .req_undef(req_undef), .req_swi(req_swi),
        .req_pabt(req_pabt), .req_dabt(req_dabt), .req_irq(req_irq), .req_fiq(req_fiq),
        .pc_i(pc_i), .cpsr_wr(cpsr_wr), .cpsr_wdata(cpsr_wdata), .ret_req(ret_req),
        .take_o(take_o), .vector_o(vector_o), .mode_o(mode_o), .cpsr_o(cpsr_o),
        .spsr_we_o(spsr_we_o), .spsr_sel_o(spsr_sel_o), .spsr_wdata_o(spsr_wdata_o),
        .lr_o(lr_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Request bit order: 0 reset,1 undef,2 swi,3 pabt,4 dabt,5 irq,6 fiq.
    task automatic drive_req(input logic [6:0] r);
        {req_fiq, req_irq, req_dabt, req_pabt, req_swi, req_undef, req_reset} = r;
    endtask

    task automatic load_cpsr(input logic [31:0] v);
        @(negedge clk); cpsr_wr = 1; cpsr_wdata = v;
        @(negedge clk); cpsr_wr = 0;
    endtask

    // Winner per the ranking; -1 when nothing is takeable.
    function automatic int winner(input logic [6:0] r, input logic [31:0] c);
        int order [7] = '{0, 4, 6, 5, 3, 1, 2};
        foreach (order[k]) begin
            if (r[order[k]] && !(order[k] == 5 && c[7]) && !(order[k] == 6 && c[6]))
                return order[k];
        end
        return -1;
    endfunction

    task automatic run_case(input logic [6:0] r, input logic [31:0] base, input logic [31:0] pc);
        int w;
        logic [31:0] exp_vec, exp_cpsr;
        logic [4:0]  exp_mode;
        logic [2:0]  exp_bank;
        load_cpsr(base);
        chk(cpsr_o == base, "R11 load", cpsr_o, base);
        w = winner(r, base);
        @(negedge clk); drive_req(r); pc_i = pc;
        @(posedge clk); #1;
        if (w < 0) begin
            chk(take_o == 0, "R4 masked no take", 32'(take_o), 0);
            chk(cpsr_o == base, "R4 masked cpsr kept", cpsr_o, base);
        end else begin
            case (w)
                0: begin exp_vec = 32'h00; exp_mode = 5'h13; exp_bank = 2; end
                1: begin exp_vec = 32'h04; exp_mode = 5'h1B; exp_bank = 4; end
                2: begin exp_vec = 32'h08; exp_mode = 5'h13; exp_bank = 2; end
                3: begin exp_vec = 32'h0C; exp_mode = 5'h17; exp_bank = 3; end
                4: begin exp_vec = 32'h10; exp_mode = 5'h17; exp_bank = 3; end
                5: begin exp_vec = 32'h18; exp_mode = 5'h12; exp_bank = 1; end
                default: begin exp_vec = 32'h1C; exp_mode = 5'h11; exp_bank = 0; end
            endcase
            exp_cpsr = {base[31:8], 1'b1, (w == 0 || w == 6) ? 1'b1 : base[6], 1'b0, exp_mode};
            chk(take_o == 1, "R8 take", 32'(take_o), 1);
            chk(vector_o == exp_vec, "R3 R2 vector", vector_o, exp_vec);
            chk(vector_o != 32'h14, "R12 reserved", vector_o, exp_vec);
            chk(mode_o == exp_mode, "R2 mode", 32'(mode_o), 32'(exp_mode));
            chk(cpsr_o == exp_cpsr, "R5 cpsr", cpsr_o, exp_cpsr);
            chk(spsr_we_o == 1 && spsr_sel_o == exp_bank, "R6 bank", 32'(spsr_sel_o), 32'(exp_bank));
            chk(spsr_wdata_o == base, "R6 saved", spsr_wdata_o, base);
            chk(lr_o == pc + 4, "R7 link", lr_o, pc + 4);
        end
        @(negedge clk); drive_req('0);
        @(posedge clk); #1;
        chk(take_o == 0, "R8 pulse ends", 32'(take_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk(cpsr_o == 32'hD3, "R1 cpsr", cpsr_o, 32'hD3);
        chk(take_o == 0 && spsr_we_o == 0, "R1 strobes", 32'(take_o), 0);

        // Every single request and every pair, interrupts unmasked.
        for (int i = 0; i < 7; i++)
            for (int j = i; j < 7; j++)
                run_case(7'(1 << i) | 7'(1 << j), 32'h6000_0030 | 32'(i), 32'h1000 + 32'(16 * j));

        // Interrupts masked in several ways.
        run_case(7'b010_0000, 32'h0000_0090, 32'h200);
        run_case(7'b100_0000, 32'h0000_0050, 32'h204);
        run_case(7'b110_1000, 32'h0000_00D0, 32'h208);
        run_case(7'b110_0000, 32'h0000_0050, 32'h20C);
        run_case(7'b110_0000, 32'h0000_0090, 32'h210);

        // Request held for two cycles: second sample ignored (R8).
        load_cpsr(32'h0000_0010);
        @(negedge clk); req_undef = 1;
        @(negedge clk);
        @(posedge clk); #1;
        chk(take_o == 0, "R8 busy cycle ignored", 32'(take_o), 0);
        @(negedge clk); req_undef = 0;

        // Entry then return restores the saved word (R9).
        load_cpsr(32'hA000_0010);
        @(negedge clk); req_irq = 1;
        @(negedge clk); req_irq = 0;
        #1;
        chk(cpsr_o == 32'hA000_0092, "R9 after entry", cpsr_o, 32'hA000_0092);
        @(negedge clk); ret_req = 1;
        @(negedge clk); ret_req = 0;
        chk(cpsr_o == 32'hA000_0010, "R9 restored", cpsr_o, 32'hA000_0010);

        // Return in user and system mode ignored (R10).
        load_cpsr(32'h4000_0010);
        @(negedge clk); ret_req = 1;
        @(negedge clk); ret_req = 0;
        chk(cpsr_o == 32'h4000_0010, "R10 user", cpsr_o, 32'h4000_0010);
        load_cpsr(32'h2000_001F);
        @(negedge clk); ret_req = 1;
        @(negedge clk); ret_req = 0;
        chk(cpsr_o == 32'h2000_001F, "R10 system", cpsr_o, 32'h2000_001F);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog actual=0x0 expected=0x1");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule